// File: doc/BRIEF.md
# Program Counter Sequencer with Skip and Return Stack

This block produces the 13-bit instruction fetch address for a small 8-bit controller core. Each cycle it is given the class of the instruction now executing: an ordinary instruction, a bit-test that skips when the bit is clear, a subroutine call, or a return. It then picks the next fetch address. The decode logic supplies the class, the 11-bit call immediate, the value of the tested register bit, and the page latch register.

The fetch runs one instruction ahead of execution. A taken skip, a call or a return therefore leaves one wrongly fetched word in the execute slot. The block raises `flush` for that slot, and the word then runs as a NOP. While `flush` is high the block treats the slot as a NOP whatever class is applied.

A call computes its target by joining bits 4:3 of the page latch, as the top two address bits, with the 11-bit immediate. In the same cycle it pushes the return address onto an internal eight-entry circular stack and shows that address on `pushData` with `pushStrobe` high. A return pops the newest entry into the full PC.

Top module: `pc_sequencer`

## Requirements
- R1: While synchronous reset `rst` is high, the next clock edge sets `fetchAddr` to 0 and `flush` to 0. With `rst` high, `pushStrobe` is 0 for every class input except 2'b10 (call).
- R2: With class 2'b00 (ordinary) and `flush` low, `fetchAddr` rises by one at the next edge. It wraps from 8191 to 0.
- R3: With class 2'b01 (skip-if-clear), `testBit` = 1 and `flush` low, `fetchAddr` rises by one and `flush` stays low in the next cycle.
- R4: With class 2'b01, `testBit` = 0 and `flush` low, `flush` is high in the next cycle and `fetchAddr` still rises by one.
- R5: With class 2'b10 (call) and `flush` low, `pushStrobe` is high in the same cycle. `pushData` then equals the current `fetchAddr`, which is the call's own address plus one.
- R6: After a call, the next `fetchAddr` is {pageLatch[4:3], immAddr[10:0]}.
- R7: A call or a return (class 2'b11) raises `flush` for exactly one cycle after it. During that cycle the class input is ignored: there is no push and no pop, and `fetchAddr` rises by one.
- R8: A return sets `fetchAddr` at the next edge to the most recently pushed address that has not yet been popped.
- R9: The stack holds 8 entries and wraps. A ninth push without a pop overwrites the oldest entry. After nine pushes, the first eight returns yield pushes 9 down to 2 and the ninth return yields push 9 again.
- R10: Bits of `pageLatch` other than 4:3 do not affect the call target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrClass | input | 2 | Executing instruction class: 00 ordinary, 01 skip-if-clear, 10 call, 11 return |
| immAddr | input | 11 | Call target immediate |
| testBit | input | 1 | Value of the tested register bit |
| pageLatch | input | 8 | Page latch register; bits 4:3 give the call page |
| fetchAddr | output | 13 | Current fetch address |
| flush | output | 1 | Execute slot holds a discarded word, run as NOP |
| pushData | output | 13 | Return address being pushed |
| pushStrobe | output | 1 | A push happens this cycle |

## Verification
The hardest condition to reach is a stack that has wrapped, with a pop that lands on an overwritten slot. Reaching it takes nine calls in a row with no return between them. Each call must be followed by its flush cycle. The bench drives nine calls to distinct targets, so each push carries a distinct address. It then issues nine returns and checks the order of the popped addresses, including the repeat of the newest one. Each call also has a class applied during its flush cycle, which shows that input is ignored there.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'b00,
    CLS_SKIPCLR = 2'b01,
    CLS_CALL = 2'b10,
    CLS_RETURN = 2'b11
  } instrClass_e;

  typedef struct packed {
    logic loadCall;
    logic loadRet;
    logic push;
    logic pop;
  } pcsCtrl_t;

endpackage

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  instrClass,
  input  logic        testBit,
  output pcsCtrl_t    ctrl,
  output logic        flush
);

  logic flushQ;
  logic active;
  logic flushNext;
  instrClass_e cls;

  assign cls    = instrClass_e'(instrClass);
  assign active = !flushQ;

  always_comb begin
    ctrl          = '0;
    flushNext     = 1'b0;
    if (active) begin
      unique case (cls)
        CLS_CALL: begin
          ctrl.loadCall = 1'b1;
          ctrl.push     = 1'b1;
          flushNext     = 1'b1;
        end
        CLS_RETURN: begin
          ctrl.loadRet = 1'b1;
          ctrl.pop     = 1'b1;
          flushNext    = 1'b1;
        end
        CLS_SKIPCLR: flushNext = !testBit;
        default: flushNext = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flushQ <= 1'b0;
    else     flushQ <= flushNext;
  end

  assign flush = flushQ;

endmodule

// File: rtl/pcs_return_stack.sv
module pcs_return_stack #(
  parameter int PC_W = 13,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] pushVal,
  output logic [PC_W-1:0] topVal
);

  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] spPrev;
  logic [PC_W-1:0] entry [DEPTH];

  assign spPrev = (sp == '0) ? SP_W'(DEPTH - 1) : sp - 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (sp == SP_W'(gi))) entry[gi] <= pushVal;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push) sp <= (sp == SP_W'(DEPTH - 1)) ? '0 : sp + 1'b1;
    else if (pop) sp <= spPrev;
  end

  assign topVal = entry[spPrev];

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int IMM_W = 11,
  parameter int PAGE_W = 8,
  parameter int PAGE_LO = 3,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pcsCtrl_t          ctrl,
  input  logic [IMM_W-1:0]  immAddr,
  input  logic [PAGE_W-1:0] pageLatch,
  output logic [PC_W-1:0]   pc
);

  localparam int PG_BITS = PC_W - IMM_W;

  logic [PC_W-1:0] callTarget;
  logic [PC_W-1:0] retTarget;
  logic [PC_W-1:0] pcNext;

  assign callTarget = {pageLatch[PAGE_LO+PG_BITS-1:PAGE_LO], immAddr};

  pcs_return_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk),
    .rst(rst),
    .push(ctrl.push),
    .pop(ctrl.pop),
    .pushVal(pc),
    .topVal(retTarget)
  );

  always_comb begin
    if (ctrl.loadCall)     pcNext = callTarget;
    else if (ctrl.loadRet) pcNext = retTarget;
    else                   pcNext = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int IMM_W = 11,
  parameter int PAGE_W = 8,
  parameter int PAGE_LO = 3,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        instrClass,
  input  logic [IMM_W-1:0]  immAddr,
  input  logic              testBit,
  input  logic [PAGE_W-1:0] pageLatch,
  output logic [PC_W-1:0]   fetchAddr,
  output logic              flush,
  output logic [PC_W-1:0]   pushData,
  output logic              pushStrobe
);

  pcsCtrl_t ctrl;

  pcs_control u_ctrl (
    .clk(clk),
    .rst(rst),
    .instrClass(instrClass),
    .testBit(testBit),
    .ctrl(ctrl),
    .flush(flush)
  );

  pcs_datapath #(
    .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .ctrl(ctrl),
    .immAddr(immAddr),
    .pageLatch(pageLatch),
    .pc(fetchAddr)
  );

  assign pushData   = fetchAddr;
  assign pushStrobe = ctrl.push;

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int PC_W = 13,
  parameter int IMM_W = 11,
  parameter int PAGE_W = 8,
  parameter int PAGE_LO = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        instrClass,
  input logic [IMM_W-1:0]  immAddr,
  input logic              testBit,
  input logic [PAGE_W-1:0] pageLatch,
  input logic [PC_W-1:0]   fetchAddr,
  input logic              flush,
  input logic [PC_W-1:0]   pushData,
  input logic              pushStrobe
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fetchAddr == '0) && !flush);

  p_seq_incr_r2: assert property (@(posedge clk) disable iff (rst)
    (!flush && instrClass == 2'b00) |=> fetchAddr == PC_W'($past(fetchAddr) + 1'b1));

  p_skip_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (!flush && instrClass == 2'b01 && testBit) |=> !flush);

  p_skip_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (!flush && instrClass == 2'b01 && !testBit) |=> flush);

  p_call_target_r6: assert property (@(posedge clk) disable iff (rst)
    (!flush && instrClass == 2'b10) |=>
      fetchAddr == {$past(pageLatch[PAGE_LO+1:PAGE_LO]), $past(immAddr)});

  p_call_flush_r7: assert property (@(posedge clk) disable iff (rst)
    pushStrobe |=> flush);

  p_flush_single_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  p_flush_nopush_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> !pushStrobe);

  p_flush_incr_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> fetchAddr == PC_W'($past(fetchAddr) + 1'b1));

endmodule

bind pc_sequencer pcs_checker #(
  .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO)
) u_chk (
  .clk(clk), .rst(rst), .instrClass(instrClass), .immAddr(immAddr),
  .testBit(testBit), .pageLatch(pageLatch), .fetchAddr(fetchAddr),
  .flush(flush), .pushData(pushData), .pushStrobe(pushStrobe)
);

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  instrClass = 2'b00;
  logic [10:0] immAddr = '0;
  logic        testBit = 1'b0;
  logic [7:0]  pageLatch = '0;
  logic [12:0] fetchAddr;
  logic        flush;
  logic [12:0] pushData;
  logic        pushStrobe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst(rst), .instrClass(instrClass), .immAddr(immAddr),
    .testBit(testBit), .pageLatch(pageLatch), .fetchAddr(fetchAddr),
    .flush(flush), .pushData(pushData), .pushStrobe(pushStrobe)
  );

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply inputs just after a falling edge, settle, caller checks, then tick
  task automatic drive(input logic [1:0] c, input logic [10:0] im, input logic tb,
                       input logic [7:0] pg);
    instrClass = c; immAddr = im; testBit = tb; pageLatch = pg;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    drive(2'b10, 11'h123, 1'b0, 8'h18);
    tick();
    chk("R1 fetchAddr", fetchAddr, 13'h0);
    chk("R1 flush", {12'h0, flush}, 13'h0);
    drive(2'b00, 11'h0, 1'b0, 8'h0);
    chk("R1 pushStrobe", {12'h0, pushStrobe}, 13'h0);
    rst = 1'b0;
  endtask

  task automatic testNormal();
    logic [12:0] base;
    base = fetchAddr;
    for (int i = 1; i <= 5; i++) begin
      drive(2'b00, 11'h0, 1'b0, 8'h0);
      tick();
      chk("R2 increment", fetchAddr, base + 13'(i));
    end
  endtask

  task automatic testSkip();
    logic [12:0] base;
    base = fetchAddr;
    drive(2'b01, 11'h0, 1'b1, 8'h0);
    tick();
    chk("R3 addr", fetchAddr, base + 13'd1);
    chk("R3 no flush", {12'h0, flush}, 13'h0);
    drive(2'b01, 11'h0, 1'b0, 8'h0);
    tick();
    chk("R4 flush", {12'h0, flush}, 13'h1);
    chk("R4 addr", fetchAddr, base + 13'd2);
    // class ignored in flush slot: a call here must not push or jump
    drive(2'b10, 11'h7FF, 1'b0, 8'h18);
    chk("R7 no push in flush", {12'h0, pushStrobe}, 13'h0);
    tick();
    chk("R7 addr after ignored call", fetchAddr, base + 13'd3);
    chk("R7 flush cleared", {12'h0, flush}, 13'h0);
  endtask

  task automatic doCall(input logic [10:0] im, input logic [7:0] pg,
                        output logic [12:0] ret, input logic [12:0] expTgt);
    drive(2'b10, im, 1'b0, pg);
    ret = fetchAddr;
    chk("R5 pushStrobe", {12'h0, pushStrobe}, 13'h1);
    chk("R5 pushData", pushData, ret);
    tick();
    chk("R6 target", fetchAddr, expTgt);
    chk("R7 flush after call", {12'h0, flush}, 13'h1);
    drive(2'b11, 11'h0, 1'b0, 8'h0); // return in flush slot must be ignored
    tick();
    chk("R7 flush slot advance", fetchAddr, expTgt + 13'd1);
  endtask

  task automatic doReturn(input logic [12:0] expAddr, input string req);
    drive(2'b11, 11'h0, 1'b0, 8'h0);
    tick();
    chk(req, fetchAddr, expAddr);
    chk("R7 flush after return", {12'h0, flush}, 13'h1);
    drive(2'b00, 11'h0, 1'b0, 8'h0);
    tick();
  endtask

  task automatic testCallReturn();
    logic [12:0] r1;
    logic [12:0] r2;
    doCall(11'h5A5, 8'hF7, r1, 13'h15A5); // R10: only bits 4:3 = 2'b10 matter
    drive(2'b00, 11'h0, 1'b0, 8'h0);
    tick();
    doCall(11'h010, 8'hE0, r2, 13'h0010); // R10: bits 4:3 = 0, others set
    doReturn(r2, "R8 inner return");
    doReturn(r1, "R8 outer return");
  endtask

  task automatic testOverflow();
    logic [12:0] rets [9];
    for (int i = 0; i < 9; i++) begin
      logic [12:0] r;
      doCall(11'(100 * i + 7), 8'h08, r, {2'b01, 11'(100 * i + 7)});
      rets[i] = r;
    end
    for (int i = 8; i >= 1; i--) doReturn(rets[i], "R9 pop order");
    doReturn(rets[8], "R9 wrapped pop");
  endtask

  task automatic testWrap();
    logic [12:0] r;
    drive(2'b10, 11'h7FE, 1'b0, 8'h18);
    r = fetchAddr;
    tick();
    chk("R6 top page", fetchAddr, 13'h1FFE);
    drive(2'b00, 11'h0, 1'b0, 8'h0);
    tick();
    chk("R2 pre-wrap", fetchAddr, 13'h1FFF);
    tick();
    chk("R2 wrap", fetchAddr, 13'h0000);
    doReturn(r, "R8 return after wrap");
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    testReset();
    testNormal();
    testSkip();
    testCallReturn();
    testOverflow();
    testWrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule